// File: doc/BRIEF.md
# Duty-Limited Fixed-Frequency PWM with Overvoltage Blanking

This block turns a digital duty demand into a gate-drive pulse train at a fixed switching frequency. Every period starts with the gate high for a number of clock cycles proportional to the demand word, and ends low. The on-time never exceeds a hard ceiling of a set percentage of the period, so the switch always gets a guaranteed off interval.

Two protection paths can stop the pulses. A bulk-overvoltage comparator flag must stay asserted for a qualification window before it blanks the gate. The blanking does not latch: once the flag drops, pulses come back at the next period boundary. A force-off input ends a pulse in progress on the next clock, and it keeps the gate low for the rest of that period.

With the default parameters the period is 2500 cycles of a 250 MHz clock, which gives 100 kHz. The ceiling is 90 %. The qualification window is 30000 cycles, which is 120 us.

Top module: `dutylim_pwm`

## Requirements
- R1: While `en` is high, successive rising edges of `gate` are exactly `PERIOD_CYC` clock cycles apart.
- R2: The pulse width in cycles is floor(`duty` * `PERIOD_CYC` / 2^`DUTY_W`). `duty` is sampled only at the last cycle of a period, or while `en` is low. A change in the middle of a period first affects the following pulse.
- R3: The pulse width never exceeds floor(`PERIOD_CYC` * `MAX_PCT` / 100) cycles. Any larger computed width is cut down to that value.
- R4: `ov_flag` blanks the gate only after it has been high for `OV_QUAL_CYC` consecutive clock cycles. A run that is one cycle shorter has no effect on `gate` or `clamp_active`.
- R5: Once the overvoltage flag qualifies, `gate` is low from the next cycle on and `clamp_active` reads 1. `clamp_active` returns to 0 at the first period boundary after the flag drops. Pulses resume at that boundary.
- R6: A high `force_off` drives `gate` low on the next clock. The gate stays low for the rest of the period, even if `force_off` is released. The next period produces a full-width pulse.
- R7: A pulse only ever begins at the first cycle of a period. Neither protection path lets the gate resume in the middle of a period.
- R8: A computed width of zero, for example `duty` = 0 or `duty` = 1 with the test sizes, produces no high cycle at all.
- R9: While `en` is low, `gate` is low and the period counter is held at its start. Pulsing begins with a fresh period when `en` rises, and dropping `en` ends a pulse on the next clock.
- R10: During and right after reset, `gate` and `clamp_active` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the output off and restarts the period |
| duty | input | DUTY_W | Duty demand, full scale 2^DUTY_W |
| ov_flag | input | 1 | Raw bulk-overvoltage comparator flag |
| force_off | input | 1 | Fault force-off, aborts the current pulse |
| gate | output | 1 | Registered gate-drive output |
| clamp_active | output | 1 | High while overvoltage blanking is in force |

## Verification
Fixed demands are applied below the ceiling, exactly at it and above it, and at zero and one. Together they separate the proportional scaling, the clamp and the zero-width case. About twenty random demand words taken from a seeded generator then check the width formula across the range.

Directed timing patterns show the cycle-exact behaviour of the protection paths. A demand change in the middle of a period shows when the demand is sampled. A force-off pulse inside a pulse must cut it and leave the gate low until the next boundary. An overvoltage run that lasts the full window must blank the gate at a known cycle, and the gate must not come back until the boundary after release. A run one cycle shorter must change nothing.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  // Largest allowed on-time in cycles for a period and a ceiling percentage.
  function automatic int unsigned max_on(input int unsigned period, input int unsigned pct);
    return (period * pct) / 100;
  endfunction
endpackage

// File: rtl/dlp_period_timer.sv
module dlp_period_timer #(
  parameter int PERIOD_CYC = 2500,
  localparam int CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  assign last = (cnt == CNT_W'(PERIOD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (last)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(PERIOD_CYC - 1)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && last) |=> (cnt == '0)); // R1
endmodule

// File: rtl/dlp_duty_scaler.sv
module dlp_duty_scaler #(
  parameter int PERIOD_CYC = 2500,
  parameter int DUTY_W     = 8,
  parameter int MAX_PCT    = 90,
  localparam int CNT_W  = $clog2(PERIOD_CYC),
  localparam int PROD_W = DUTY_W + CNT_W + 1,
  localparam int MAXON  = int'(dlp_pkg::max_on(PERIOD_CYC, MAX_PCT))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty,
  output logic [CNT_W-1:0]  on_len
);
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] limited;

  always_comb begin
    prod    = PROD_W'(duty) * PROD_W'(PERIOD_CYC);
    scaled  = prod >> DUTY_W;
    limited = (scaled > PROD_W'(MAXON)) ? PROD_W'(MAXON) : scaled;
  end

  always_ff @(posedge clk) begin
    if (rst)       on_len <= '0;
    else if (load) on_len <= CNT_W'(limited);
  end

  AST_ONLEN_CEIL: assert property (@(posedge clk) disable iff (rst)
    on_len <= CNT_W'(MAXON)); // R3
  AST_ONLEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(on_len)); // R2
endmodule

// File: rtl/dlp_ov_qualifier.sv
module dlp_ov_qualifier #(
  parameter int OV_QUAL_CYC = 30000,
  localparam int QW = $clog2(OV_QUAL_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ov_in,
  output logic ov_qual
);
  logic [QW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !ov_in) begin
      run     <= '0;
      ov_qual <= 1'b0;
    end else if (run == QW'(OV_QUAL_CYC - 1)) begin
      ov_qual <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  AST_OV_DROP: assert property (@(posedge clk) disable iff (rst)
    !ov_in |=> !ov_qual); // R4
  AST_OV_RUN_CAP: assert property (@(posedge clk) disable iff (rst)
    run <= QW'(OV_QUAL_CYC - 1)); // R4
endmodule

// File: rtl/dutylim_pwm.sv
module dutylim_pwm #(
  parameter int PERIOD_CYC  = 2500,
  parameter int DUTY_W      = 8,
  parameter int MAX_PCT     = 90,
  parameter int OV_QUAL_CYC = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty,
  input  logic              ov_flag,
  input  logic              force_off,
  output logic              gate,
  output logic              clamp_active
);
  localparam int CNT_W = $clog2(PERIOD_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] on_len;
  logic             last;
  logic             boundary;
  logic             ov_qual;
  logic             ov_hold;
  logic             kill;

  dlp_period_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt), .last(last)
  );

  assign boundary = last || !en;

  dlp_duty_scaler #(.PERIOD_CYC(PERIOD_CYC), .DUTY_W(DUTY_W), .MAX_PCT(MAX_PCT)) i_scaler (
    .clk(clk), .rst(rst), .load(boundary), .duty(duty), .on_len(on_len)
  );

  dlp_ov_qualifier #(.OV_QUAL_CYC(OV_QUAL_CYC)) i_ovq (
    .clk(clk), .rst(rst), .ov_in(ov_flag), .ov_qual(ov_qual)
  );

  // Blanking holds to the end of the period in which it was last requested.
  always_ff @(posedge clk) begin
    if (rst)           ov_hold <= 1'b0;
    else if (ov_qual)  ov_hold <= 1'b1;
    else if (boundary) ov_hold <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)             kill <= 1'b0;
    else if (force_off)  kill <= 1'b1;
    else if (boundary)   kill <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate         <= 1'b0;
      clamp_active <= 1'b0;
    end else begin
      gate         <= en && !force_off && !kill && !ov_qual && !ov_hold && (cnt < on_len);
      clamp_active <= ov_hold;
    end
  end

  AST_FORCE_CUTS: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !gate); // R6
  AST_OV_BLANKS: assert property (@(posedge clk) disable iff (rst)
    ov_qual |=> !gate); // R5
  AST_HOLD_BLANKS: assert property (@(posedge clk) disable iff (rst)
    ov_hold |=> !gate); // R5
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> ($past(cnt) == '0)); // R7
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (on_len == '0) |=> !gate); // R8
endmodule

// File: tb/test_dutylim_pwm.sv
module test_dutylim_pwm;
  localparam int P   = 100;
  localparam int W   = 8;
  localparam int MX  = 90;
  localparam int Q   = 40;
  localparam int MAXON = (P * MX) / 100;

  logic clk = 1'b0;
  logic rst, en, ov_flag, force_off;
  logic [W-1:0] duty;
  logic gate, clamp_active;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dutylim_pwm #(.PERIOD_CYC(P), .DUTY_W(W), .MAX_PCT(MX), .OV_QUAL_CYC(Q)) i_dutylim_pwm (
    .clk(clk), .rst(rst), .en(en), .duty(duty), .ov_flag(ov_flag),
    .force_off(force_off), .gate(gate), .clamp_active(clamp_active)
  );

  function automatic int exp_len(input int d);
    int v;
    v = (d * P) / (1 << W);
    return (v > MAXON) ? MAXON : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    repeat (P) begin
      @(negedge clk);
      if (gate) n++;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = gate;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (gate && !prev) return;
      prev = gate;
    end
  endtask

  task automatic steady(input int d, input string req);
    int n;
    duty = W'(d);
    repeat (2 * P) @(negedge clk);
    count_high(n);
    chk(n == exp_len(d), req, n, exp_len(d));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, el, wid;
    bit stayed;
    void'($urandom(32'd24681));
    rst = 1'b1; en = 1'b0; duty = '0; ov_flag = 1'b0; force_off = 1'b0;
    repeat (5) @(negedge clk);
    chk(gate == 1'b0 && clamp_active == 1'b0, "R10 reset", {gate, clamp_active}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0 && clamp_active == 1'b0, "R10 after reset", {gate, clamp_active}, 0);

    // R9: disabled output stays low
    duty = 8'd200;
    count_high(n);
    chk(n == 0, "R9 disabled", n, 0);

    en = 1'b1;
    steady(128, "R2 half");
    wait_rise();
    el = 0;
    do begin @(negedge clk); el++; end while (!(gate && el > 1 && !clamp_active) || el < 2 ? 1'b0 : 1'b0);
    // measure rise-to-rise spacing
    el = 0;
    begin
      logic prev;
      prev = gate;
      for (int i = 0; i < 3 * P; i++) begin
        @(negedge clk);
        el++;
        if (gate && !prev) break;
        prev = gate;
      end
    end
    chk(el == P - 1 || el == P, "R1 spacing", el, P);

    steady(255, "R3 full scale");
    steady(240, "R3 above ceiling");
    steady(230, "R2 just below ceiling");
    steady(0, "R8 zero demand");
    steady(1, "R8 tiny demand");

    // R2: mid-period demand change affects next pulse only
    steady(200, "R2 base");
    wait_rise();
    repeat (5) @(negedge clk);
    duty = 8'd50;
    wid = 6;
    while (gate) begin @(negedge clk); if (gate) wid++; end
    chk(wid == exp_len(200), "R2 mid-period change", wid, exp_len(200));
    wait_rise();
    wid = 1;
    while (gate) begin @(negedge clk); if (gate) wid++; end
    chk(wid == exp_len(50), "R2 next period", wid, exp_len(50));

    // R6 / R7: force-off abort
    duty = 8'd200;
    repeat (2 * P) @(negedge clk);
    wait_rise();
    repeat (10) @(negedge clk);
    force_off = 1'b1;
    @(negedge clk);
    chk(gate == 1'b0, "R6 force cuts pulse", gate, 0);
    repeat (2) @(negedge clk);
    force_off = 1'b0;
    el = 13;
    while (!gate && el < 3 * P) begin @(negedge clk); el++; end
    chk(el == P, "R7 force resume at boundary", el, P);
    wid = 1;
    while (gate) begin @(negedge clk); if (gate) wid++; end
    chk(wid == exp_len(200), "R6 full pulse after force", wid, exp_len(200));

    // R4 / R5 / R7: qualified overvoltage
    wait_rise();
    repeat (5) @(negedge clk);
    ov_flag = 1'b1;
    el = 5;
    while (gate && el < P) begin @(negedge clk); el++; end
    chk(el == Q + 6, "R4 blank after window", el, Q + 6);
    @(negedge clk); el++;
    chk(clamp_active == 1'b1, "R5 clamp active", clamp_active, 1);
    stayed = 1'b1;
    while (el < P + 20) begin @(negedge clk); el++; if (gate) stayed = 1'b0; end
    chk(stayed, "R5 blank across boundary", stayed, 1);
    ov_flag = 1'b0;
    while (!gate && el < 4 * P) begin @(negedge clk); el++; end
    chk(el == 2 * P, "R7 ov resume at boundary", el, 2 * P);
    chk(clamp_active == 1'b0, "R5 non-latching clamp", clamp_active, 0);

    // R4: one cycle short of the window
    repeat (P / 2) @(negedge clk);
    ov_flag = 1'b1;
    stayed = 1'b1;
    repeat (Q - 1) begin @(negedge clk); if (clamp_active) stayed = 1'b0; end
    ov_flag = 1'b0;
    repeat (3) begin @(negedge clk); if (clamp_active) stayed = 1'b0; end
    chk(stayed, "R4 short run no clamp", stayed, 1);
    repeat (P) @(negedge clk);
    count_high(n);
    chk(n == exp_len(200), "R4 short run pulses intact", n, exp_len(200));

    // R9: dropping enable ends a pulse
    wait_rise();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0, "R9 enable drop", gate, 0);
    en = 1'b1;

    // R2 / R3: random demands
    for (int k = 0; k < 20; k++) begin
      steady(int'($urandom_range(0, (1 << W) - 1)), "R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule